// File: doc/BRIEF.md
# Self-Refresh Scheduler with Partial-Array Masking

This block keeps the cells of a pseudo-static memory alive while the host leaves the device alone. An interval timer runs at a rate chosen by the temperature setting. On each expiry it raises a row refresh request, which is held until the row arbiter grants it. The row address walks only the part of the array that the configuration marks as retained. That part is a power-of-two fraction aligned to the bottom or the top of the row space. Rows outside it never see a request.

A seven-bit configuration register holds the retained fraction, the anchor end, the rate setting and a deep power-down bit. It is written over two paths. The dedicated path can write every field. The software-sequence path writes every field except deep power-down. While deep power-down is set, all refresh stops. Clearing it starts a fixed initialization wait, during which the ready flag stays low. The status output tells the host when the device is in a low-power state.

Top module: `selfrefresh_ctrl`

## Requirements
- R1: After reset, ref_req_o is low, ready_o is high and ref_row_o is 0. The configuration resets to full array, low anchor, automatic rate and deep power-down off.
- R2: ref_req_o is high only while ce_ni is high (standby) and ready_o is high. lowpwr_o is high when ce_ni is high or deep power-down is active.
- R3: Once raised, ref_req_o stays high until a cycle in which grant_i is also high. ref_row_o changes only on such a cycle or on a configuration write.
- R4: Configuration bits [2:0] select the retained part: 000 full, 001 half, 010 quarter, 011 eighth, and any larger code none. Bit [3] set anchors that part at the highest rows, clear at row 0. Every granted row lies inside the part, and with none no request is raised.
- R5: After a grant the row advances by one inside the part and returns from the part's last row to its first.
- R6: A configuration write that leaves the row outside the new part moves the row to the part's first row. Otherwise the row is kept, so rows added by enlarging the part are reached without delay.
- R7: Bits [5:4] select the rate: 01, 10 and 11 give request spacings of IVL_T15, IVL_T45 and IVL_T85 cycles when grants are immediate.
- R8: Rate code 00 follows temp_code_i: 0, 1, 2 and 3 give IVL_T15, IVL_T45, IVL_T85 and IVL_HOT.
- R9: Bit [6] set through the dedicated path stops all requests, drives ready_o low and drives lowpwr_o high.
- R10: Clearing bit [6] through the dedicated path keeps ready_o low, with no request, for exactly INIT_CYC cycles after the write edge.
- R11: A software-sequence write updates bits [5:0] and leaves bit [6] unchanged. If both write strobes are high, the dedicated write is taken.
- R12: Timer expiries that occur while a request is already waiting merge into that request, and one grant clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low; high means standby |
| cfg_dir_we_i | input | 1 | Dedicated-path configuration write strobe |
| cfg_seq_we_i | input | 1 | Software-sequence configuration write strobe |
| cfg_wdata_i | input | 7 | Configuration write data |
| temp_code_i | input | 2 | Temperature sensor code |
| grant_i | input | 1 | Row arbiter grant |
| ref_req_o | output | 1 | Row refresh request |
| ref_row_o | output | ROW_W | Row to refresh |
| ready_o | output | 1 | Normal operation available |
| lowpwr_o | output | 1 | Standby or deep power-down status |

## Verification
The hardest state to reach is a configuration write landing in the same cycle as a granted refresh. The row must first take its advance inside the old partition and then be snapped into the new one. Fixed-rate phases cannot line these two events up. So a long random phase writes the register over both paths with random fields, while grant and chip enable toggle at random. A bench model of the row walk checks every granted row, including across those collisions. Directed phases first reach known timer phases by synchronizing on a request pulse, and only then measure spacings, merged expiries and the length of the initialization wait.

// File: rtl/selfrefresh_pkg.sv
package selfrefresh_pkg;

  localparam int CFG_W = 7;

  typedef struct packed {
    logic       dpd;
    logic [1:0] temp;
    logic       anchor_hi;
    logic [2:0] size;
  } sr_cfg_t;

  localparam sr_cfg_t CFG_RST = '0;

  localparam logic [1:0] TEMP_AUTO = 2'b00;
  localparam logic [1:0] TEMP_T15  = 2'b01;
  localparam logic [1:0] TEMP_T45  = 2'b10;
  localparam logic [1:0] TEMP_T85  = 2'b11;

  typedef enum logic [1:0] {
    RATE_T15 = 2'd0,
    RATE_T45 = 2'd1,
    RATE_T85 = 2'd2,
    RATE_HOT = 2'd3
  } rate_e;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_DPD  = 2'd1,
    PWR_INIT = 2'd2
  } pwr_e;

  function automatic logic part_none(input logic [2:0] size);
    return size > 3'd3;
  endfunction

  function automatic logic [1:0] part_shift(input logic [2:0] size);
    return size[1:0];
  endfunction

endpackage

// File: rtl/sr_cfg_reg.sv
module sr_cfg_reg
  import selfrefresh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_we_i,
  input  logic             seq_we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output sr_cfg_t          cfg_q_o,
  output sr_cfg_t          cfg_d_o,
  output logic             upd_o
);

  sr_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (dir_we_i) begin
      cfg_d = sr_cfg_t'(wdata_i);
    end else if (seq_we_i) begin
      cfg_d     = sr_cfg_t'(wdata_i);
      cfg_d.dpd = cfg_q.dpd;  // power-down bit reachable only via dedicated path
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= cfg_d;
  end

  assign cfg_q_o = cfg_q;
  assign cfg_d_o = cfg_d;
  assign upd_o   = dir_we_i | seq_we_i;

endmodule

// File: rtl/sr_interval_timer.sv
module sr_interval_timer
  import selfrefresh_pkg::*;
#(
  parameter int IVL_T15 = 1560,
  parameter int IVL_T45 = 780,
  parameter int IVL_T85 = 390,
  parameter int IVL_HOT = 195,
  parameter int CNT_W   = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] temp_i,
  input  logic [1:0] sensor_i,
  output logic       tick_o
);

  rate_e            rate;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] tmr_q;
  logic             tick;

  always_comb begin
    unique case (temp_i)
      TEMP_T15: rate = RATE_T15;
      TEMP_T45: rate = RATE_T45;
      TEMP_T85: rate = RATE_T85;
      default:  rate = rate_e'(sensor_i);
    endcase
  end

  always_comb begin
    unique case (rate)
      RATE_T15: lim = CNT_W'(IVL_T15 - 1);
      RATE_T45: lim = CNT_W'(IVL_T45 - 1);
      RATE_T85: lim = CNT_W'(IVL_T85 - 1);
      default:  lim = CNT_W'(IVL_HOT - 1);
    endcase
  end

  // >= so that a switch to a shorter interval never overruns
  assign tick = run_i && (tmr_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmr_q <= '0;
    else if (!run_i) tmr_q <= '0;
    else if (tick)   tmr_q <= '0;
    else             tmr_q <= tmr_q + 1'b1;
  end

  assign tick_o = tick;

endmodule

// File: rtl/sr_pwr_seq.sv
module sr_pwr_seq
  import selfrefresh_pkg::*;
#(
  parameter int INIT_CYC = 7500,
  parameter int INIT_W   = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dpd_d_i,
  output logic run_o,
  output logic dpd_o
);

  pwr_e              st_q, st_d;
  logic [INIT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PWR_RUN: if (dpd_d_i) st_d = PWR_DPD;
      PWR_DPD: begin
        if (!dpd_d_i) begin
          st_d  = PWR_INIT;
          cnt_d = '0;
        end
      end
      PWR_INIT: begin
        if (dpd_d_i)                                 st_d = PWR_DPD;
        else if (cnt_q == INIT_W'(INIT_CYC - 1))     st_d = PWR_RUN;
        else                                         cnt_d = cnt_q + 1'b1;
      end
      default: st_d = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PWR_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign run_o = (st_q == PWR_RUN);
  assign dpd_o = (st_q == PWR_DPD);

endmodule

// File: rtl/sr_row_sched.sv
module sr_row_sched
  import selfrefresh_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sr_cfg_t          cfg_q_i,
  input  sr_cfg_t          cfg_d_i,
  input  logic             upd_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             ce_ni,
  input  logic             grant_i,
  output logic             req_o,
  output logic [ROW_W-1:0] row_o
);

  localparam logic [ROW_W-1:0] ALL1 = '1;

  function automatic logic [ROW_W-1:0] mask_of(input sr_cfg_t c);
    return ALL1 >> part_shift(c.size);
  endfunction

  function automatic logic [ROW_W-1:0] base_of(input sr_cfg_t c);
    return c.anchor_hi ? ~mask_of(c) : '0;
  endfunction

  // an empty partition keeps the row where it is
  function automatic logic in_part(input logic [ROW_W-1:0] r, input sr_cfg_t c);
    return part_none(c.size) || ((r & ~mask_of(c)) == base_of(c));
  endfunction

  logic             pend_q, pend_d;
  logic [ROW_W-1:0] row_q, row_a, row_d;
  logic             none_q, req, hs;

  assign none_q = part_none(cfg_q_i.size);
  assign req    = pend_q & ce_ni & run_i & ~none_q;
  assign hs     = req & grant_i;

  always_comb begin
    row_a = hs ? (base_of(cfg_q_i) | ((row_q + 1'b1) & mask_of(cfg_q_i))) : row_q;
    row_d = (upd_i && !in_part(row_a, cfg_d_i)) ? base_of(cfg_d_i) : row_a;
  end

  always_comb begin
    if (!run_i || none_q) pend_d = 1'b0;
    else if (tick_i)      pend_d = 1'b1;  // merges with a waiting request
    else if (hs)          pend_d = 1'b0;
    else                  pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      pend_q <= pend_d;
      row_q  <= row_d;
    end
  end

  assign req_o = req;
  assign row_o = row_q;

endmodule

// File: rtl/selfrefresh_ctrl.sv
module selfrefresh_ctrl
  import selfrefresh_pkg::*;
#(
  parameter int ROW_W    = 10,
  parameter int INIT_CYC = 7500,
  parameter int IVL_T15  = 1560,
  parameter int IVL_T45  = 780,
  parameter int IVL_T85  = 390,
  parameter int IVL_HOT  = 195
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             cfg_dir_we_i,
  input  logic             cfg_seq_we_i,
  input  logic [6:0]       cfg_wdata_i,
  input  logic [1:0]       temp_code_i,
  input  logic             grant_i,
  output logic             ref_req_o,
  output logic [ROW_W-1:0] ref_row_o,
  output logic             ready_o,
  output logic             lowpwr_o
);

  localparam int IVL_M1  = (IVL_T15 > IVL_T45) ? IVL_T15 : IVL_T45;
  localparam int IVL_M2  = (IVL_T85 > IVL_HOT) ? IVL_T85 : IVL_HOT;
  localparam int IVL_MAX = (IVL_M1 > IVL_M2) ? IVL_M1 : IVL_M2;
  localparam int CNT_W   = $clog2(IVL_MAX + 1);
  localparam int INIT_W  = $clog2(INIT_CYC + 1);

  sr_cfg_t cfg_q, cfg_d;
  logic    cfg_upd, run, dpd_act, tick;

  sr_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dir_we_i (cfg_dir_we_i),
    .seq_we_i (cfg_seq_we_i),
    .wdata_i  (cfg_wdata_i),
    .cfg_q_o  (cfg_q),
    .cfg_d_o  (cfg_d),
    .upd_o    (cfg_upd)
  );

  sr_pwr_seq #(
    .INIT_CYC (INIT_CYC),
    .INIT_W   (INIT_W)
  ) u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dpd_d_i (cfg_d.dpd),
    .run_o   (run),
    .dpd_o   (dpd_act)
  );

  sr_interval_timer #(
    .IVL_T15 (IVL_T15),
    .IVL_T45 (IVL_T45),
    .IVL_T85 (IVL_T85),
    .IVL_HOT (IVL_HOT),
    .CNT_W   (CNT_W)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .temp_i   (cfg_q.temp),
    .sensor_i (temp_code_i),
    .tick_o   (tick)
  );

  sr_row_sched #(
    .ROW_W (ROW_W)
  ) u_row (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_q_i (cfg_q),
    .cfg_d_i (cfg_d),
    .upd_i   (cfg_upd),
    .run_i   (run),
    .tick_i  (tick),
    .ce_ni   (ce_ni),
    .grant_i (grant_i),
    .req_o   (ref_req_o),
    .row_o   (ref_row_o)
  );

  assign ready_o  = run;
  assign lowpwr_o = ce_ni | dpd_act;

endmodule

// File: rtl/selfrefresh_ctrl_chk.sv
module selfrefresh_ctrl_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             cfg_dir_we_i,
  input logic             cfg_seq_we_i,
  input logic             grant_i,
  input logic             ref_req_o,
  input logic [ROW_W-1:0] ref_row_o,
  input logic             ready_o,
  input logic [6:0]       cfg_i
);

  localparam logic [ROW_W-1:0] ALL1 = '1;

  logic [ROW_W-1:0] pmask, pbase;

  always_comb begin
    pmask = ALL1 >> cfg_i[1:0];
    pbase = cfg_i[3] ? ~pmask : '0;
  end

  // R2
  req_in_standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> (ce_ni && ready_o));

  // R3
  req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !grant_i && !cfg_dir_we_i && !cfg_seq_we_i) |=> (ref_req_o || !ce_ni));

  // R3
  row_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ref_req_o && grant_i) && !cfg_dir_we_i && !cfg_seq_we_i) |=> $stable(ref_row_o));

  // R4
  row_in_part_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> ((cfg_i[2:0] <= 3'd3) && ((ref_row_o & ~pmask) == pbase)));

  // R9
  dpd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i[6] |-> (!ready_o && !ref_req_o));

  // R11
  seq_keeps_dpd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_seq_we_i && !cfg_dir_we_i) |=> $stable(cfg_i[6]));

endmodule

bind selfrefresh_ctrl selfrefresh_ctrl_chk #(.ROW_W(ROW_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ce_ni        (ce_ni),
  .cfg_dir_we_i (cfg_dir_we_i),
  .cfg_seq_we_i (cfg_seq_we_i),
  .grant_i      (grant_i),
  .ref_req_o    (ref_req_o),
  .ref_row_o    (ref_row_o),
  .ready_o      (ready_o),
  .cfg_i        (cfg_q)
);

// File: tb/selfrefresh_ctrl_tb_top.sv
`timescale 1ns/1ps
module selfrefresh_ctrl_tb_top;

  localparam int RW   = 4;
  localparam int INIT = 20;
  localparam int T15  = 10;
  localparam int T45  = 7;
  localparam int T85  = 5;
  localparam int THOT = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_ni = 1'b1;
  logic          dir_we = 1'b0;
  logic          seq_we = 1'b0;
  logic [6:0]    wdata = '0;
  logic [1:0]    tcode = '0;
  logic          grant = 1'b1;
  logic          req;
  logic [RW-1:0] row;
  logic          ready;
  logic          lowpwr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [6:0]    cfg_m = '0;
  logic [RW-1:0] exp_row = '0;

  always #10 clk = ~clk;

  selfrefresh_ctrl #(
    .ROW_W    (RW),
    .INIT_CYC (INIT),
    .IVL_T15  (T15),
    .IVL_T45  (T45),
    .IVL_T85  (T85),
    .IVL_HOT  (THOT)
  ) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .ce_ni        (ce_ni),
    .cfg_dir_we_i (dir_we),
    .cfg_seq_we_i (seq_we),
    .cfg_wdata_i  (wdata),
    .temp_code_i  (tcode),
    .grant_i      (grant),
    .ref_req_o    (req),
    .ref_row_o    (row),
    .ready_o      (ready),
    .lowpwr_o     (lowpwr)
  );

  function automatic logic [RW-1:0] m_mask(input logic [6:0] c);
    return 4'hF >> c[1:0];
  endfunction
  function automatic logic [RW-1:0] m_base(input logic [6:0] c);
    return c[3] ? ~m_mask(c) : '0;
  endfunction
  function automatic logic m_none(input logic [6:0] c);
    return c[2:0] > 3'd3;
  endfunction
  function automatic logic m_in(input logic [RW-1:0] r, input logic [6:0] c);
    return m_none(c) || ((r & ~m_mask(c)) == m_base(c));
  endfunction
  function automatic logic [RW-1:0] m_next(input logic [RW-1:0] r, input logic [6:0] c);
    return m_base(c) | (RW'(r + 1'b1) & m_mask(c));
  endfunction
  function automatic logic [6:0] mk(input logic d, input logic [1:0] t, input logic a,
                                    input logic [2:0] s);
    return {d, t, a, s};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: check granted row against model, update model, advance
  task automatic clk_step(input string tag);
    #1;
    if (req) begin
      chk({tag, " R2 req needs standby"}, ce_ni, 1);
      chk({tag, " R9 req outside dpd"}, cfg_m[6], 0);
      chk({tag, " R4 req with part"}, m_none(cfg_m), 0);
    end
    if (req && grant) begin
      chk({tag, " R5 granted row"}, row, exp_row);
      exp_row = m_next(exp_row, cfg_m);
    end
    if (dir_we) cfg_m = wdata;
    else if (seq_we) cfg_m[5:0] = wdata[5:0];
    if ((dir_we || seq_we) && !m_in(exp_row, cfg_m)) exp_row = m_base(cfg_m);
    @(negedge clk);
    #1;
    dir_we = 1'b0;
    seq_we = 1'b0;
  endtask

  task automatic wr(input logic dir, input logic [6:0] v, input string tag);
    wdata  = v;
    dir_we = dir;
    seq_we = !dir;
    clk_step(tag);
  endtask

  task automatic wait_req(output int n, input string tag);
    n = 0;
    do begin
      clk_step(tag);
      n++;
    end while (!req && n < 300);
  endtask

  task automatic gap(input int exp, input string tag);
    int n;
    wait_req(n, tag);
    wait_req(n, tag);
    chk(tag, n, exp);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    logic [RW-1:0] hold_row;
    n = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1 req at reset", req, 0);
    chk("R1 ready at reset", ready, 1);
    chk("R1 row at reset", row, 0);
    chk("R2 lowpwr in standby", lowpwr, 1);

    // R1 default auto mode with code 0 gives the longest spacing
    gap(T15, "R1 default rate");

    // R7 fixed rates
    wr(1, mk(0, 2'b01, 0, 3'd0), "R7");
    gap(T15, "R7 rate 01");
    wr(1, mk(0, 2'b10, 0, 3'd0), "R7");
    gap(T45, "R7 rate 10");
    wr(1, mk(0, 2'b11, 0, 3'd0), "R7");
    gap(T85, "R7 rate 11");

    // R8 automatic mode follows the sensor
    wr(1, mk(0, 2'b00, 0, 3'd0), "R8");
    for (int c = 0; c < 4; c++) begin
      tcode = 2'(c);
      gap((c == 0) ? T15 : (c == 1) ? T45 : (c == 2) ? T85 : THOT, "R8 sensor rate");
    end

    // R4 R5 partitions and wrap
    wr(1, mk(0, 2'b11, 0, 3'd1), "R4 half low");
    repeat (12) wait_req(n, "R5 half low");
    wr(1, mk(0, 2'b11, 1, 3'd3), "R6 eighth high");
    chk("R6 snap to top eighth", row, 14);
    repeat (5) wait_req(n, "R5 eighth high");
    wr(1, mk(0, 2'b11, 1, 3'd1), "R4 half high");
    repeat (10) wait_req(n, "R5 half high");
    wr(1, mk(0, 2'b11, 0, 3'd2), "R6 quarter low");
    chk("R6 snap to row 0", row, 0);
    repeat (6) wait_req(n, "R5 quarter low");

    // R6 enlarging keeps the row and uses new rows at once
    wr(1, mk(0, 2'b11, 0, 3'd3), "R6 eighth low");
    wait_req(n, "R6 eighth low");
    wait_req(n, "R6 eighth low");
    hold_row = row;
    wr(1, mk(0, 2'b11, 0, 3'd0), "R6 grow to full");
    chk("R6 row kept on growth", row, (hold_row == 4'd1 || hold_row == 4'd0) ? exp_row : 99);
    repeat (4) wait_req(n, "R6 grown rows");

    // R4 none
    wr(1, mk(0, 2'b11, 0, 3'd4), "R4 none");
    n = 0;
    for (int c = 0; c < 40; c++) begin
      if (req) n++;
      clk_step("R4 none");
    end
    chk("R4 no req with none", n, 0);
    wr(1, mk(0, 2'b01, 0, 3'd0), "R4 full");

    // R3 R12 hold without grant, merged expiries
    wait_req(n, "R12 sync");
    grant = 1'b0;
    hold_row = row;
    n = 0;
    for (int c = 0; c < 25; c++) begin
      clk_step("R3 hold");
      if (!req) n++;
    end
    chk("R3 req held", n, 0);
    chk("R3 row held", row, hold_row);
    grant = 1'b1;
    clk_step("R12 grant");
    chk("R12 merged request cleared", req, 0);

    // R2 chip enable low blocks requests, pending kept
    ce_ni = 1'b0;
    n = 0;
    for (int c = 0; c < 30; c++) begin
      #1;
      if (req) n++;
      clk_step("R2 active");
    end
    chk("R2 no req when active", n, 0);
    chk("R2 lowpwr when active", lowpwr, 0);
    ce_ni = 1'b1;
    #1;
    chk("R2 req on standby", req, 1);
    chk("R2 lowpwr on standby", lowpwr, 1);

    // R11 software path cannot set power-down, other fields taken
    wr(0, mk(1, 2'b11, 0, 3'd0), "R11 seq");
    ce_ni = 1'b0;
    #1;
    chk("R11 dpd unchanged lowpwr", lowpwr, 0);
    chk("R11 ready kept", ready, 1);
    ce_ni = 1'b1;
    gap(T85, "R11 rate field taken");
    // both strobes: dedicated wins
    wdata = mk(0, 2'b10, 0, 3'd0);
    dir_we = 1'b1;
    seq_we = 1'b1;
    clk_step("R11 both");
    gap(T45, "R11 dedicated wins");

    // R9 deep power-down
    wr(1, mk(1, 2'b10, 0, 3'd0), "R9 enter");
    chk("R9 ready low", ready, 0);
    ce_ni = 1'b0;
    #1;
    chk("R9 lowpwr high", lowpwr, 1);
    ce_ni = 1'b1;
    n = 0;
    for (int c = 0; c < 40; c++) begin
      #1;
      if (req) n++;
      clk_step("R9 quiet");
    end
    chk("R9 no req", n, 0);

    // R10 initialization wait
    wr(1, mk(0, 2'b11, 0, 3'd0), "R10 leave");
    n = 0;
    while (!ready && n < 200) begin
      if (req) errors++;
      n++;
      clk_step("R10 wait");
    end
    chk("R10 init length", n, INIT);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      int r;
      ce_ni = ($urandom % 8) != 0;
      grant = ($urandom % 3) != 0;
      if ((c % 50) == 0) tcode = 2'($urandom);
      r = $urandom % 100;
      if (r < 3) begin
        wdata  = mk(($urandom % 8) == 0, 2'($urandom), 1'($urandom), 3'($urandom % 6));
        dir_we = 1'b1;
      end else if (r < 6) begin
        wdata  = 7'($urandom);
        seq_we = 1'b1;
      end
      clk_step("rand");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule